// File: doc/BRIEF.md
# Crossbar Periphery Mode Sequencer

This block drives the digital side of a resistive compute-in-memory array. It accepts a mode command for a cell write, a plain read or a multiply-accumulate. For that mode it raises a fixed set of global control lines and the per-column select lines that set up the bitline and sourceline select circuits. The row input vector and the column-select pattern each arrive one bit at a time. They are shifted into two registers, so the wordlines and column selects can later be driven in parallel as full-on or full-off levels.

For read and multiply-accumulate, the sequencer first powers the read path and keeps the wordlines low until the drivers report that they have settled. It then applies the input vector and holds everything for a programmable evaluation window. In multiply-accumulate mode, groups of adjacent columns share one converter. The window is repeated once per column position in a group, and a per-column steering line marks the columns whose weight bit is converted in that window. A one-cycle done pulse ends each operation, and all lines return low before the next command is taken.

Top module: `cim_periph_seq`

## Requirements
- R1: In reset and in idle, every control line, column select, steering line and wordline is 0, and cmd_ready, wl_in_ready and col_in_ready are 1.
- R2: During an operation the lines {ctl_write, ctl_read, ctl_mac, ctl_set, ctl_reset} are {1,0,0,dir,!dir} for write (cmd_op=01), {0,1,0,0,0} for read (cmd_op=10) and {1,0,1,0,0} for multiply-accumulate (cmd_op=11). col_select equals the loaded column pattern. cmd_op=00 starts nothing.
- R3: The i-th bit accepted on the wordline serial input, counting from 0, lands on wl[i]. The i-th bit accepted on the column serial input lands on col_select[i].
- R4: If a serial load ends (bit accepted with its last flag) after a bit count other than ROWS (wordlines) or COLS (columns), load_err goes to 1. It stays 1 until a command that starts an operation is accepted.
- R5: A read or multiply-accumulate first spends at least one cycle with its control lines active and wl at 0. The wordlines are applied in the cycle after drv_ready is sampled high.
- R6: With W = eval_cycles, or 1 when eval_cycles is 0, a write keeps its lines active for W cycles. A read keeps them active for 1+W cycles and a multiply-accumulate for 1+GROUP*W cycles, each case with drv_ready held high.
- R7: In multiply-accumulate window k (k = 0..GROUP-1), col_macsel[c] is 1 exactly when column c is selected and c mod GROUP equals k. The drive cycle uses k = 0. Outside multiply-accumulate, col_macsel is 0.
- R8: After the last active cycle, eval_done is 1 for exactly one cycle with all lines at 0 and cmd_ready at 0. cmd_ready returns to 1 in the next cycle.
- R9: A write command is refused when the wordline register or the column register does not hold exactly one 1. A refused command leaves every line at 0, keeps cmd_ready at 1 and sets load_err.
- R10: While an operation is in progress, cmd_ready, wl_in_ready and col_in_ready are 0. Commands and serial bits offered then have no effect on later operations or on load_err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken (idle) |
| cmd_op | input | 2 | 01 write, 10 read, 11 multiply-accumulate, 00 none |
| cmd_dir | input | 1 | Write direction: 1 set, 0 reset |
| cmd_eval | input | TW | Evaluation window length in cycles |
| wl_in_valid | input | 1 | Wordline serial bit offered |
| wl_in_ready | output | 1 | Wordline serial bit can be taken |
| wl_in_bit | input | 1 | Wordline serial data |
| wl_in_last | input | 1 | Last bit of a wordline load |
| col_in_valid | input | 1 | Column serial bit offered |
| col_in_ready | output | 1 | Column serial bit can be taken |
| col_in_bit | input | 1 | Column serial data |
| col_in_last | input | 1 | Last bit of a column load |
| drv_ready | input | 1 | Read drivers settled |
| ctl_write | output | 1 | Global write-path enable |
| ctl_read | output | 1 | Global read-path enable |
| ctl_mac | output | 1 | Global multiply-accumulate enable |
| ctl_set | output | 1 | Set driver enable |
| ctl_reset | output | 1 | Reset driver enable |
| col_select | output | COLS | Per-column select |
| col_macsel | output | COLS | Per-column converter steering |
| wl | output | ROWS | Wordline levels |
| eval_done | output | 1 | Operation finished pulse |
| load_err | output | 1 | Load length mismatch or refused write |

## Verification
The assertions take for granted that drv_ready eventually rises once a read or multiply-accumulate is in its drive phase. They also assume that cmd_op stays within its four codes. They rely on a write only ever reaching the array with one-hot row and column patterns, which the block enforces itself. The stimulus always raises drv_ready within a few cycles and offers only defined opcodes. It deliberately offers commands and serial bits while the block is busy, so that the ignored-input cases are exercised.

// File: rtl/cim_periph_seq.sv
module cim_periph_seq #(
  parameter int ROWS  = 16,
  parameter int COLS  = 8,
  parameter int GROUP = 4,
  parameter int TW    = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  output logic            cmd_ready,
  input  logic [1:0]      cmd_op,
  input  logic            cmd_dir,
  input  logic [TW-1:0]   cmd_eval,
  input  logic            wl_in_valid,
  output logic            wl_in_ready,
  input  logic            wl_in_bit,
  input  logic            wl_in_last,
  input  logic            col_in_valid,
  output logic            col_in_ready,
  input  logic            col_in_bit,
  input  logic            col_in_last,
  input  logic            drv_ready,
  output logic            ctl_write,
  output logic            ctl_read,
  output logic            ctl_mac,
  output logic            ctl_set,
  output logic            ctl_reset,
  output logic [COLS-1:0] col_select,
  output logic [COLS-1:0] col_macsel,
  output logic [ROWS-1:0] wl,
  output logic            eval_done,
  output logic            load_err
);
  localparam int PW  = (GROUP > 1) ? $clog2(GROUP) : 1;
  localparam int RCW = $clog2(ROWS + 2);
  localparam int CCW = $clog2(COLS + 2);
  localparam logic [1:0] OP_W = 2'b01, OP_R = 2'b10, OP_M = 2'b11;

  typedef enum logic [1:0] {S_IDLE, S_DRIVE, S_EVAL, S_DONE} st_t;

  st_t             st;
  logic [1:0]      op;
  logic            dir;
  logic [TW-1:0]   win, cnt;
  logic [PW-1:0]   phase;
  logic [ROWS-1:0] wl_sr;
  logic [COLS-1:0] col_sr;
  logic [RCW-1:0]  wl_cnt;
  logic [CCW-1:0]  col_cnt;
  logic            err;
  logic [COLS-1:0] pmask;

  wire idle   = (st == S_IDLE);
  wire active = (st == S_DRIVE) || (st == S_EVAL);
  wire wl_one  = (wl_sr != '0)  && ((wl_sr  & (wl_sr  - 1'b1)) == '0);
  wire col_one = (col_sr != '0) && ((col_sr & (col_sr - 1'b1)) == '0);
  wire win_end = (cnt == win - 1'b1);
  wire last_ph = (phase == PW'(GROUP - 1));

  assign cmd_ready    = idle;
  assign wl_in_ready  = idle;
  assign col_in_ready = idle;

  assign ctl_write = active && (op == OP_W || op == OP_M);
  assign ctl_read  = active && (op == OP_R);
  assign ctl_mac   = active && (op == OP_M);
  assign ctl_set   = active && (op == OP_W) && dir;
  assign ctl_reset = active && (op == OP_W) && !dir;

  generate
    for (genvar c = 0; c < COLS; c++) begin : g_mask
      assign pmask[c] = (PW'(c % GROUP) == phase);
    end
  endgenerate

  assign col_select = active  ? col_sr          : '0;
  assign col_macsel = ctl_mac ? (col_sr & pmask) : '0;
  assign wl         = (st == S_EVAL) ? wl_sr : '0;
  assign eval_done  = (st == S_DONE);
  assign load_err   = err;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      op      <= 2'b00;
      dir     <= 1'b0;
      win     <= '0;
      cnt     <= '0;
      phase   <= '0;
      wl_sr   <= '0;
      col_sr  <= '0;
      wl_cnt  <= '0;
      col_cnt <= '0;
      err     <= 1'b0;
    end else begin
      case (st)
        S_IDLE: begin
          if (cmd_valid) begin
            cnt   <= '0;
            phase <= '0;
            win   <= (cmd_eval == '0) ? TW'(1) : cmd_eval;
            dir   <= cmd_dir;
            if (cmd_op == OP_W) begin
              if (wl_one && col_one) begin
                op  <= OP_W;
                st  <= S_EVAL;
                err <= 1'b0;
              end else begin
                err <= 1'b1;
              end
            end else if (cmd_op != 2'b00) begin
              op  <= cmd_op;
              st  <= S_DRIVE;
              err <= 1'b0;
            end
          end
          if (wl_in_valid) begin
            wl_sr <= {wl_in_bit, wl_sr[ROWS-1:1]};
            if (wl_in_last) begin
              wl_cnt <= '0;
              if (wl_cnt + 1'b1 != RCW'(ROWS)) err <= 1'b1;
            end else if (wl_cnt != '1) begin
              wl_cnt <= wl_cnt + 1'b1;
            end
          end
          if (col_in_valid) begin
            col_sr <= {col_in_bit, col_sr[COLS-1:1]};
            if (col_in_last) begin
              col_cnt <= '0;
              if (col_cnt + 1'b1 != CCW'(COLS)) err <= 1'b1;
            end else if (col_cnt != '1) begin
              col_cnt <= col_cnt + 1'b1;
            end
          end
        end
        S_DRIVE: begin
          if (drv_ready) begin
            st  <= S_EVAL;
            cnt <= '0;
          end
        end
        S_EVAL: begin
          if (win_end) begin
            cnt <= '0;
            if (op == OP_M && !last_ph) phase <= phase + 1'b1;
            else st <= S_DONE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cim_periph_seq_chk.sv
module cim_periph_seq_chk #(
  parameter int ROWS = 16,
  parameter int COLS = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cmd_ready,
  input logic            ctl_write,
  input logic            ctl_read,
  input logic            ctl_mac,
  input logic            ctl_set,
  input logic            ctl_reset,
  input logic [COLS-1:0] col_select,
  input logic [COLS-1:0] col_macsel,
  input logic [ROWS-1:0] wl,
  input logic            eval_done
);
  wire any_ctl = ctl_write | ctl_read | ctl_mac | ctl_set | ctl_reset;

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (!any_ctl && col_select == '0 && col_macsel == '0 && wl == '0));

  a_r2_dir_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctl_set && ctl_reset));

  a_r2_mac_code: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_mac |-> (ctl_write && !ctl_read && !ctl_set && !ctl_reset));

  a_r9_write_single: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_write && !ctl_mac) |-> ($countones(col_select) == 1 && $countones(wl) == 1));

  a_r5_drive_first: assert property (@(posedge clk) disable iff (!rst_n)
    ((ctl_mac || ctl_read) && $rose(|wl)) |-> $past(ctl_mac || ctl_read));

  a_r7_macsel_subset: assert property (@(posedge clk) disable iff (!rst_n)
    (col_macsel != '0) |-> (ctl_mac && (col_macsel & ~col_select) == '0));

  a_r8_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    eval_done |-> (!any_ctl && wl == '0 && !cmd_ready));

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    eval_done |=> (!eval_done && cmd_ready));
endmodule

bind cim_periph_seq cim_periph_seq_chk #(.ROWS(ROWS), .COLS(COLS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_ready(cmd_ready),
  .ctl_write(ctl_write), .ctl_read(ctl_read), .ctl_mac(ctl_mac),
  .ctl_set(ctl_set), .ctl_reset(ctl_reset), .col_select(col_select),
  .col_macsel(col_macsel), .wl(wl), .eval_done(eval_done)
);

// File: tb/cim_periph_seq_test.sv
module cim_periph_seq_test;
  localparam int ROWS = 16, COLS = 8, GROUP = 4, TW = 16;

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, cmd_dir = 0;
  logic [1:0] cmd_op = 0;
  logic [TW-1:0] cmd_eval = 0;
  logic wl_in_valid = 0, wl_in_bit = 0, wl_in_last = 0;
  logic col_in_valid = 0, col_in_bit = 0, col_in_last = 0;
  logic drv_ready = 1;
  logic cmd_ready, wl_in_ready, col_in_ready;
  logic ctl_write, ctl_read, ctl_mac, ctl_set, ctl_reset, eval_done, load_err;
  logic [COLS-1:0] col_select, col_macsel;
  logic [ROWS-1:0] wl;

  int checks = 0, failures = 0;

  always #4 clk = ~clk;

  cim_periph_seq #(.ROWS(ROWS), .COLS(COLS), .GROUP(GROUP), .TW(TW)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_dir(cmd_dir), .cmd_eval(cmd_eval),
    .wl_in_valid(wl_in_valid), .wl_in_ready(wl_in_ready), .wl_in_bit(wl_in_bit),
    .wl_in_last(wl_in_last), .col_in_valid(col_in_valid), .col_in_ready(col_in_ready),
    .col_in_bit(col_in_bit), .col_in_last(col_in_last), .drv_ready(drv_ready),
    .ctl_write(ctl_write), .ctl_read(ctl_read), .ctl_mac(ctl_mac),
    .ctl_set(ctl_set), .ctl_reset(ctl_reset), .col_select(col_select),
    .col_macsel(col_macsel), .wl(wl), .eval_done(eval_done), .load_err(load_err)
  );

  // op(2) dir(1) wl(16) col(8) eval(16) ctl{w,r,m,s,rs}(5) active_len(8)
  localparam logic [55:0] VEC [5] = '{
    {2'b01, 1'b1, 16'h0008, 8'h04, 16'd3, 5'b10010, 8'd3},
    {2'b01, 1'b0, 16'h8000, 8'h80, 16'd1, 5'b10001, 8'd1},
    {2'b10, 1'b0, 16'hA5C3, 8'hFF, 16'd4, 5'b01000, 8'd5},
    {2'b11, 1'b0, 16'h00FF, 8'h0F, 16'd2, 5'b10100, 8'd9},
    {2'b10, 1'b1, 16'h0001, 8'h5A, 16'd0, 5'b01000, 8'd2}
  };

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load_wl(input logic [ROWS-1:0] pat, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wl_in_valid = 1; wl_in_bit = pat[i]; wl_in_last = (i == n - 1);
    end
    @(negedge clk);
    wl_in_valid = 0; wl_in_last = 0;
  endtask

  task automatic load_col(input logic [COLS-1:0] pat, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      col_in_valid = 1; col_in_bit = pat[i]; col_in_last = (i == n - 1);
    end
    @(negedge clk);
    col_in_valid = 0; col_in_last = 0;
  endtask

  task automatic do_cmd(input logic [1:0] op, input logic dir, input logic [TW-1:0] ev);
    @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_dir = dir; cmd_eval = ev;
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic wait_done();
    for (int g = 0; g < 2000 && !eval_done; g++) @(negedge clk);
    @(negedge clk);
  endtask

  function automatic logic [COLS-1:0] exp_macsel(input logic [COLS-1:0] col, input int k);
    logic [COLS-1:0] m = '0;
    for (int c = 0; c < COLS; c++) if ((c % GROUP) == k) m[c] = col[c];
    return m;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [4:0] c5;
    int act;
    logic [ROWS-1:0] last_wl;

    repeat (3) @(negedge clk);
    chk({ctl_write, ctl_read, ctl_mac, ctl_set, ctl_reset} == 0 && wl == 0 && col_select == 0 &&
        col_macsel == 0 && eval_done == 0, "R1 reset outputs", {wl, col_select}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(cmd_ready && wl_in_ready && col_in_ready && !load_err, "R1 idle readies",
        {cmd_ready, wl_in_ready, col_in_ready, load_err}, 4'b1110);

    // table walk: R2 R3 R6 R8
    for (int v = 0; v < 5; v++) begin
      load_wl(VEC[v][52:37], ROWS);
      load_col(VEC[v][36:29], COLS);
      do_cmd(VEC[v][55:54], VEC[v][53], VEC[v][28:13]);
      c5 = {ctl_write, ctl_read, ctl_mac, ctl_set, ctl_reset};
      chk(c5 == VEC[v][12:8], "R2 control code", c5, VEC[v][12:8]);
      chk(col_select == VEC[v][36:29], "R3 column order", col_select, VEC[v][36:29]);
      act = 0; last_wl = 0;
      for (int g = 0; g < 1000 && !eval_done; g++) begin
        if (ctl_write || ctl_read) act++;
        last_wl = wl;
        @(negedge clk);
      end
      chk(act == int'(VEC[v][7:0]), "R6 active length", act, VEC[v][7:0]);
      chk(last_wl == VEC[v][52:37], "R3 wordline order", last_wl, VEC[v][52:37]);
      chk(eval_done && !cmd_ready && wl == 0 && !ctl_write && !ctl_read, "R8 done cycle",
          {eval_done, cmd_ready, wl}, 18'h20000);
      @(negedge clk);
      chk(!eval_done && cmd_ready, "R8 done single", {eval_done, cmd_ready}, 2'b01);
    end

    // R5: wordlines wait for drv_ready
    load_wl(16'hF00F, ROWS);
    load_col(8'h33, COLS);
    drv_ready = 0;
    do_cmd(2'b11, 0, 1);
    chk(ctl_mac && wl == 0, "R5 drive before wordlines", wl, 0);
    repeat (2) @(negedge clk);
    chk(ctl_mac && wl == 0, "R5 hold while drivers settle", wl, 0);
    drv_ready = 1;
    @(negedge clk);
    chk(wl == 16'hF00F, "R5 wordlines after ready", wl, 16'hF00F);
    wait_done();

    // R7: converter steering per window
    load_col(8'hB6, COLS);
    do_cmd(2'b11, 0, 2);
    for (int k = 0; k < GROUP; k++) begin
      if (k == 0) @(negedge clk); else repeat (2) @(negedge clk);
      chk(col_macsel == exp_macsel(8'hB6, k), "R7 window steering", col_macsel, exp_macsel(8'hB6, k));
    end
    repeat (2) @(negedge clk);
    chk(eval_done == 1, "R8 done after last window", eval_done, 1);
    @(negedge clk);
    do_cmd(2'b10, 0, 1);
    chk(col_macsel == 0, "R7 no steering in read", col_macsel, 0);
    wait_done();

    // R4: length mismatch
    load_wl(16'h0004, ROWS - 1);
    chk(load_err == 1, "R4 short wordline load", load_err, 1);
    load_wl(16'h0004, ROWS);
    chk(load_err == 1, "R4 error sticky", load_err, 1);
    do_cmd(2'b10, 0, 1);
    chk(load_err == 0, "R4 cleared by command", load_err, 0);
    wait_done();
    load_col(8'h01, COLS + 1);
    chk(load_err == 1, "R4 long column load", load_err, 1);

    // R9: write refusal
    load_wl(16'h0011, ROWS);
    load_col(8'h01, COLS);
    do_cmd(2'b01, 1, 2);
    chk(cmd_ready && !ctl_write && !ctl_set && wl == 0 && load_err, "R9 refuse multi row",
        {cmd_ready, ctl_write, load_err}, 3'b101);
    load_wl(16'h0100, ROWS);
    load_col(8'h03, COLS);
    do_cmd(2'b01, 0, 2);
    chk(cmd_ready && !ctl_write && load_err, "R9 refuse multi column", {cmd_ready, ctl_write}, 2'b10);
    do_cmd(2'b00, 0, 2);
    chk(cmd_ready && !ctl_write && !ctl_read, "R2 no-op code", {cmd_ready, ctl_read}, 2'b10);

    // R10: inputs ignored while busy
    load_wl(16'h3C3C, ROWS);
    load_col(8'h81, COLS);
    do_cmd(2'b10, 0, 5);
    cmd_valid = 1; cmd_op = 2'b01; cmd_dir = 1;
    wl_in_valid = 1; wl_in_bit = 1; wl_in_last = 1;
    col_in_valid = 1; col_in_bit = 0; col_in_last = 1;
    chk(!cmd_ready && !wl_in_ready && !col_in_ready, "R10 not ready while busy",
        {cmd_ready, wl_in_ready, col_in_ready}, 0);
    @(negedge clk);
    cmd_valid = 0; wl_in_valid = 0; wl_in_last = 0; col_in_valid = 0; col_in_last = 0;
    wait_done();
    repeat (2) @(negedge clk);
    chk(!ctl_write && !ctl_set && cmd_ready && !load_err, "R10 busy command ignored",
        {ctl_write, load_err}, 0);
    do_cmd(2'b10, 0, 1);
    @(negedge clk);
    chk(wl == 16'h3C3C && col_select == 8'h81, "R10 busy bits ignored", {wl, col_select}, {16'h3C3C, 8'h81});
    wait_done();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule